// File: doc/BRIEF.md
# Performance Counter Access Port

This block is the access path in front of a small bank of performance counters. The bank holds a set of general counters and a set of fixed counters, both kept inside the block. Software-side writes reach a general counter through one of two address aliases. The narrow alias takes a 32-bit value and sign-extends it. The wide alias takes the full value and refuses anything that does not fit the counter. A third write kind loads a fixed counter.

Reads arrive as a 32-bit index word, in the style of a read-counter instruction. The upper flag bits of the word pick the counter group and a reduced 32-bit return format. The low bits pick the counter within that group. An index that names no implemented counter, or a write the rules refuse, raises a single-cycle fault pulse instead of taking effect.

Read data is registered and returned one cycle after the request, with a valid strobe. The fault output is combinational, so it is high in the same cycle as the rejected access.

Top module: `pmc_access_port`

## Requirements
- R1: After reset every counter holds zero, `rd_valid` is low and `fault` is low.
- R2: A write with `wr_kind` = 0 (narrow alias) to general counter `wr_idx` stores `wr_data[31:0]`, sign-extended to 64 bits and then truncated to `GEN_W` bits.
- R3: A write with `wr_kind` = 1 (wide alias) whose `wr_data` bits `GEN_W` and above are all zero stores `wr_data[GEN_W-1:0]` into general counter `wr_idx`.
- R4: A write with `wr_kind` = 1 whose `wr_data` has any bit set at or above bit `GEN_W` raises `fault` in that cycle and leaves every counter unchanged.
- R5: Both aliases address the same storage: a value written through either one reads back identically, and a write through one overwrites a value written through the other.
- R6: With `rd_en` high, bit 30 of `rd_index` set selects the fixed group and clear selects the general group; bits 29:0 give the counter number. For a valid index, `rd_valid` is high in the next cycle and `rd_data` carries the counter zero-extended to 64 bits.
- R7: Bit 31 of `rd_index` set selects the reduced format: `rd_data` carries only the low 32 bits of the counter, with bits 63:32 zero.
- R8: A read whose counter number is not below the size of the selected group (`NUM_GEN` or `NUM_FIX`) raises `fault` in that cycle, and `rd_valid` stays low in the next cycle.
- R9: A write with `wr_kind` = 2 stores `wr_data[FIX_W-1:0]` into fixed counter `wr_idx` and never faults on data. A write with `wr_kind` = 3, or one whose `wr_idx` is not below the size of its group, raises `fault` and changes no counter.
- R10: When a read and an accepted write address the same counter in one cycle, the read returns the value held before the write.
- R11: `fault` is high only in cycles that carry a rejected read or write. A rejected access on one side does not block an acceptable access on the other side in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_kind | input | 2 | 0 narrow alias, 1 wide alias, 2 fixed counter, 3 reserved |
| wr_idx | input | WI_W | Counter number for the write |
| wr_data | input | 64 | Write value |
| rd_en | input | 1 | Read request |
| rd_index | input | 32 | Read index word: bit 31 reduced format, bit 30 fixed group, 29:0 counter number |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | 64 | Read data |
| fault | output | 1 | Rejected access in this cycle |

## Verification
The bench goes after the sign bit of the narrow alias. A positive low word must stay positive, and a value with bit 31 set must fill the upper counter bits with ones; a design that zero-extends would return the wrong upper half. It probes the wide alias at exactly bit `GEN_W`, where an off-by-one range check would either take the value or wrongly refuse a full-width one. For invalid indexes (64, one past each group, a stray bit 29, invalid plus reduced format), a design that wraps the number would return another counter's data instead of faulting. Same-cycle read-and-write, and a bad read paired with a good write, catch designs that forward new data or let one fault suppress the other side.

// File: rtl/pmc_ap_pkg.sv
package pmc_ap_pkg;

   localparam int DATA_W     = 64;
   localparam int IDX_WORD_W = 32;
   localparam int FAST_BIT   = 31;   // reduced 32-bit return format
   localparam int GROUP_BIT  = 30;   // fixed-counter group select
   localparam int NUM_FLD_W  = 30;   // counter number field 29:0

   typedef enum logic [1:0] {
      WK_NARROW = 2'd0,
      WK_WIDE   = 2'd1,
      WK_FIXED  = 2'd2,
      WK_RSVD   = 2'd3
   } wr_kind_e;

endpackage

// File: rtl/pmc_ap_bank.sv
module pmc_ap_bank
   import pmc_ap_pkg::*;
#(
   parameter int NUM_GEN = 4,
   parameter int NUM_FIX = 3,
   parameter int GEN_W   = 48,
   parameter int FIX_W   = 48,
   parameter int WI_W    = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            gen_we,
   input  logic                            fix_we,
   input  logic [WI_W-1:0]                 idx,
   input  logic [GEN_W-1:0]                gen_d,
   input  logic [FIX_W-1:0]                fix_d,
   output logic [NUM_GEN-1:0][GEN_W-1:0]   gen_q,
   output logic [NUM_FIX-1:0][FIX_W-1:0]   fix_q
);

   logic [GEN_W-1:0] gen_r [NUM_GEN];
   logic [FIX_W-1:0] fix_r [NUM_FIX];

   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            gen_r[g] <= '0;
         else if (gen_we && (32'(idx) == g))
            gen_r[g] <= gen_d;
      end
      assign gen_q[g] = gen_r[g];
   end

   for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fix_r[f] <= '0;
         else if (fix_we && (32'(idx) == f))
            fix_r[f] <= fix_d;
      end
      assign fix_q[f] = fix_r[f];
   end

   // R9: the two write enables come from exclusive decode paths
   a_r9_one_group_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(gen_we && fix_we));

endmodule

// File: rtl/pmc_ap_wr_path.sv
module pmc_ap_wr_path
   import pmc_ap_pkg::*;
#(
   parameter int NUM_GEN = 4,
   parameter int NUM_FIX = 3,
   parameter int GEN_W   = 48,
   parameter int FIX_W   = 48,
   parameter int WI_W    = 2
) (
   input  logic                 wr_en,
   input  logic [1:0]           wr_kind,
   input  logic [WI_W-1:0]      wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   output logic                 gen_we,
   output logic                 fix_we,
   output logic [GEN_W-1:0]     gen_d,
   output logic [FIX_W-1:0]     fix_d,
   output logic                 wr_fault
);

   wr_kind_e            kind;
   logic                gen_idx_ok;
   logic                fix_idx_ok;
   logic                wide_excess;
   logic [DATA_W-1:0]   narrow_ext;
   logic                reject;

   assign kind        = wr_kind_e'(wr_kind);
   assign gen_idx_ok  = 32'(wr_idx) < NUM_GEN;
   assign fix_idx_ok  = 32'(wr_idx) < NUM_FIX;
   assign wide_excess = |wr_data[DATA_W-1:GEN_W];
   assign narrow_ext  = {{(DATA_W-32){wr_data[31]}}, wr_data[31:0]};

   always_comb begin
      reject = 1'b0;
      gen_d  = '0;
      unique case (kind)
         WK_NARROW: begin
            reject = !gen_idx_ok;
            gen_d  = narrow_ext[GEN_W-1:0];
         end
         WK_WIDE: begin
            reject = !gen_idx_ok || wide_excess;
            gen_d  = wr_data[GEN_W-1:0];
         end
         WK_FIXED: reject = !fix_idx_ok;
         default:  reject = 1'b1;
      endcase
   end

   assign fix_d    = wr_data[FIX_W-1:0];
   assign wr_fault = wr_en && reject;
   assign gen_we   = wr_en && !reject && ((kind == WK_NARROW) || (kind == WK_WIDE));
   assign fix_we   = wr_en && !reject && (kind == WK_FIXED);

endmodule

// File: rtl/pmc_ap_rd_path.sv
module pmc_ap_rd_path
   import pmc_ap_pkg::*;
#(
   parameter int NUM_GEN = 4,
   parameter int NUM_FIX = 3,
   parameter int GEN_W   = 48,
   parameter int FIX_W   = 48
) (
   input  logic                            rd_en,
   input  logic [IDX_WORD_W-1:0]           rd_index,
   input  logic [NUM_GEN-1:0][GEN_W-1:0]   gen_q,
   input  logic [NUM_FIX-1:0][FIX_W-1:0]   fix_q,
   output logic                            rd_hit,
   output logic                            rd_fault,
   output logic [DATA_W-1:0]               rd_word
);

   logic                 fast;
   logic                 grp_fix;
   logic [NUM_FLD_W-1:0] num;
   logic                 num_ok;
   logic [DATA_W-1:0]    picked;

   assign fast    = rd_index[FAST_BIT];
   assign grp_fix = rd_index[GROUP_BIT];
   assign num     = rd_index[NUM_FLD_W-1:0];
   assign num_ok  = grp_fix ? (num < NUM_FLD_W'(NUM_FIX)) : (num < NUM_FLD_W'(NUM_GEN));

   always_comb begin
      picked = '0;
      if (grp_fix) begin
         for (int f = 0; f < NUM_FIX; f++)
            if (num == NUM_FLD_W'(f)) picked = DATA_W'(fix_q[f]);
      end else begin
         for (int g = 0; g < NUM_GEN; g++)
            if (num == NUM_FLD_W'(g)) picked = DATA_W'(gen_q[g]);
      end
   end

   assign rd_word  = fast ? {32'd0, picked[31:0]} : picked;
   assign rd_hit   = rd_en && num_ok;
   assign rd_fault = rd_en && !num_ok;

endmodule

// File: rtl/pmc_access_port.sv
module pmc_access_port
   import pmc_ap_pkg::*;
#(
   parameter int NUM_GEN = 4,
   parameter int NUM_FIX = 3,
   parameter int GEN_W   = 48,
   parameter int FIX_W   = 48,
   localparam int MAX_N  = (NUM_GEN > NUM_FIX) ? NUM_GEN : NUM_FIX,
   localparam int WI_W   = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_kind,
   input  logic [WI_W-1:0]      wr_idx,
   input  logic [63:0]          wr_data,
   input  logic                 rd_en,
   input  logic [31:0]          rd_index,
   output logic                 rd_valid,
   output logic [63:0]          rd_data,
   output logic                 fault
);

   localparam int MAX_W = (GEN_W > FIX_W) ? GEN_W : FIX_W;

   initial begin : p_param_chk
      assert (NUM_GEN >= 1 && NUM_GEN <= 64) else $error("NUM_GEN out of range");
      assert (NUM_FIX >= 1 && NUM_FIX <= 64) else $error("NUM_FIX out of range");
      assert (GEN_W >= 33 && GEN_W <= 63)    else $error("GEN_W must be 33..63");
      assert (FIX_W >= 32 && FIX_W <= 64)    else $error("FIX_W must be 32..64");
   end

   logic                          gen_we, fix_we, wr_fault_w;
   logic [GEN_W-1:0]              gen_d;
   logic [FIX_W-1:0]              fix_d;
   logic [NUM_GEN-1:0][GEN_W-1:0] gen_q;
   logic [NUM_FIX-1:0][FIX_W-1:0] fix_q;
   logic                          rd_hit, rd_fault_w;
   logic [DATA_W-1:0]             rd_word;

   pmc_ap_wr_path #(.NUM_GEN(NUM_GEN), .NUM_FIX(NUM_FIX), .GEN_W(GEN_W),
                    .FIX_W(FIX_W), .WI_W(WI_W)) u_wr (
      .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
      .gen_we(gen_we), .fix_we(fix_we), .gen_d(gen_d), .fix_d(fix_d),
      .wr_fault(wr_fault_w));

   pmc_ap_bank #(.NUM_GEN(NUM_GEN), .NUM_FIX(NUM_FIX), .GEN_W(GEN_W),
                 .FIX_W(FIX_W), .WI_W(WI_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .gen_we(gen_we), .fix_we(fix_we), .idx(wr_idx),
      .gen_d(gen_d), .fix_d(fix_d), .gen_q(gen_q), .fix_q(fix_q));

   pmc_ap_rd_path #(.NUM_GEN(NUM_GEN), .NUM_FIX(NUM_FIX), .GEN_W(GEN_W),
                    .FIX_W(FIX_W)) u_rd (
      .rd_en(rd_en), .rd_index(rd_index), .gen_q(gen_q), .fix_q(fix_q),
      .rd_hit(rd_hit), .rd_fault(rd_fault_w), .rd_word(rd_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_hit;
         if (rd_hit) rd_data <= rd_word;
      end
   end

   assign fault = wr_fault_w || rd_fault_w;

   // R4 / R9: a refused write leaves the whole bank untouched
   a_r4_refused_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fault_w |=> ($stable(gen_q) && $stable(fix_q)));

   // R6: returned data never carries bits above the widest counter
   a_r6_width_masked: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ((rd_data >> MAX_W) == 64'd0));

   // R7: reduced format returns a zero upper half
   a_r7_fast_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && rd_index[FAST_BIT]) |=> (rd_valid && (rd_data[63:32] == 32'd0)));

   // R8: a refused read produces no data strobe
   a_r8_bad_read_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fault_w |=> !rd_valid);

   // R11: the fault pulse needs a request behind it
   a_r11_fault_has_request: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (wr_en || rd_en));

endmodule

// File: tb/pmc_access_port_tb.sv
module pmc_access_port_tb_top;

   localparam int NG = 4;
   localparam int NF = 3;
   localparam int GW = 48;
   localparam int FW = 40;
   localparam logic [63:0] GMASK = (64'd1 << GW) - 64'd1;
   localparam logic [63:0] FMASK = (64'd1 << FW) - 64'd1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_kind = 2'd0;
   logic [1:0]  wr_idx = 2'd0;
   logic [63:0] wr_data = 64'd0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_index = 32'd0;
   logic        rd_valid;
   logic [63:0] rd_data;
   logic        fault;

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;

   typedef struct {
      logic [63:0] data;
      int          due;
      string       tag;
   } exp_t;
   exp_t q[$];

   logic [63:0] gm [NG];
   logic [63:0] fm [NF];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pmc_access_port #(.NUM_GEN(NG), .NUM_FIX(NF), .GEN_W(GW), .FIX_W(FW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_en(rd_en), .rd_index(rd_index), .rd_valid(rd_valid),
      .rd_data(rd_data), .fault(fault));

   // monitor: pops expected read results as rd_valid appears
   always @(negedge clk) begin
      if (rst_n) begin
         if (q.size() > 0 && q[0].due < cyc) begin
            n_vec++; n_bad++;
            $display("FAIL %s: rd_valid missing, actual 0 expected 1", q[0].tag);
            void'(q.pop_front());
         end
         if (rd_valid) begin
            n_vec++;
            if (q.size() == 0) begin
               n_bad++;
               $display("FAIL R8: unexpected rd_valid, data %h expected none", rd_data);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (e.due != cyc || rd_data !== e.data) begin
                  n_bad++;
                  $display("FAIL %s: actual %h at cycle %0d expected %h at cycle %0d",
                           e.tag, rd_data, cyc, e.data, e.due);
               end
            end
         end
      end
   end

   // driver: one access per cycle, predicts fault and read results
   task automatic acc(input bit we, input logic [1:0] kind, input int widx,
                      input logic [63:0] wd, input bit re, input logic [31:0] ridx,
                      input string tag);
      bit          wbad, rbad, efault;
      logic [29:0] num;
      logic [63:0] v;
      @(negedge clk);
      wr_en = we; wr_kind = kind; wr_idx = 2'(widx); wr_data = wd;
      rd_en = re; rd_index = ridx;
      wbad = we && ((kind == 2'd3) ||
                    ((kind == 2'd2) ? (widx >= NF) : (widx >= NG)) ||
                    ((kind == 2'd1) && ((wd >> GW) != 64'd0)));
      num  = ridx[29:0];
      rbad = re && (ridx[30] ? (num >= 30'(NF)) : (num >= 30'(NG)));
      efault = wbad || rbad;
      #1;
      n_vec++;
      if (fault !== efault) begin
         n_bad++;
         $display("FAIL %s: fault actual %b expected %b", tag, fault, efault);
      end
      if (re && !rbad) begin
         exp_t e;
         v = ridx[30] ? fm[num] : gm[num];   // value before this cycle's write (R10)
         if (ridx[31]) v = {32'd0, v[31:0]};
         e.data = v; e.due = cyc + 1; e.tag = tag;
         q.push_back(e);
      end
      if (we && !wbad) begin
         case (kind)
            2'd0: gm[widx] = {{32{wd[31]}}, wd[31:0]} & GMASK;
            2'd1: gm[widx] = wd & GMASK;
            default: fm[widx] = wd & FMASK;
         endcase
      end
   endtask

   task automatic rd(input logic [31:0] ridx, input string tag);
      acc(1'b0, 2'd0, 0, 64'd0, 1'b1, ridx, tag);
   endtask

   task automatic wr(input logic [1:0] kind, input int widx, input logic [63:0] wd,
                     input string tag);
      acc(1'b1, kind, widx, wd, 1'b0, 32'd0, tag);
   endtask

   task automatic idle();
      acc(1'b0, 2'd0, 0, 64'd0, 1'b0, 32'd0, "idle");
   endtask

   initial begin : watchdog
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < NG; i++) gm[i] = 64'd0;
      for (int i = 0; i < NF; i++) fm[i] = 64'd0;
      repeat (3) @(negedge clk);
      // R1: reset state
      n_vec++;
      if (rd_valid !== 1'b0 || fault !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: rd_valid/fault actual %b%b expected 00", rd_valid, fault);
      end
      rst_n = 1'b1;
      // R1 / R6: all counters read zero, both groups
      for (int i = 0; i < NG; i++) rd(32'(i), "R1 gen zero");
      for (int i = 0; i < NF; i++) rd(32'h4000_0000 | 32'(i), "R1 fixed zero");

      // R2: narrow alias, positive and negative low words
      wr(2'd0, 0, 64'h0000_ff01_2345_6789, "R2 positive");
      rd(32'd0, "R2 positive readback");
      wr(2'd0, 1, 64'h0000_0000_89AB_CDEF, "R2 negative");
      rd(32'd1, "R2 sign fill");

      // R3 / R5: wide alias in range, then overwritten through narrow alias
      wr(2'd1, 2, 64'h0000_8123_4567_89AB, "R3 wide");
      rd(32'd2, "R3 wide readback");
      // R4: excess bits refused, counter unchanged
      wr(2'd1, 2, 64'hffff_ff01_2345_6789, "R4 excess");
      rd(32'd2, "R4 unchanged");
      wr(2'd1, 3, 64'h0001_0000_0000_0000, "R4 bit GEN_W boundary");
      rd(32'd3, "R4 boundary unchanged");
      wr(2'd1, 3, 64'h0000_FFFF_FFFF_FFFF, "R3 all ones at width");
      rd(32'd3, "R3 full width readback");
      wr(2'd0, 2, 64'hAAAA_AAAA_7FFF_FFFF, "R5 narrow over wide");
      rd(32'd2, "R5 shared storage");

      // R7: reduced format, both groups
      rd(32'h8000_0001, "R7 fast gen");
      rd(32'h8000_0003, "R7 fast gen full");

      // R9: fixed writes truncate, bad kinds and indexes refused
      wr(2'd2, 0, 64'hABff_0123_4567_89AB, "R9 fixed truncate");
      rd(32'h4000_0000, "R9 fixed readback");
      rd(32'hC000_0000, "R7 fast fixed");
      wr(2'd2, 3, 64'h1234, "R9 fixed idx beyond group");
      wr(2'd3, 1, 64'h5555, "R9 reserved kind");
      for (int i = 0; i < NG; i++) rd(32'(i), "R9 gen untouched");
      for (int i = 0; i < NF; i++) rd(32'h4000_0000 | 32'(i), "R9 fixed untouched");

      // R8: invalid indexes
      rd(32'd64, "R8 index 64");
      rd(32'd4, "R8 one past gen");
      rd(32'h4000_0003, "R8 one past fixed");
      rd(32'h2000_0000, "R8 stray bit 29");
      rd(32'h8000_0004, "R8 fast invalid");
      idle();

      // R10: read and write same counter in one cycle
      acc(1'b1, 2'd1, 0, 64'h0000_1111_2222_3333, 1'b1, 32'd0, "R10 old value");
      rd(32'd0, "R10 new value");

      // R11: bad read with good write, good read with bad write
      acc(1'b1, 2'd2, 1, 64'h0000_0077_8899_AABB, 1'b1, 32'd9, "R11 bad read good write");
      rd(32'h4000_0001, "R11 write applied");
      acc(1'b1, 2'd1, 1, 64'hFFFF_0000_0000_0000, 1'b1, 32'd1, "R11 good read bad write");
      rd(32'd1, "R11 gen1 kept");
      idle();
      idle();
      idle();
      n_vec++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R6: pending reads actual %0d expected 0", q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule